// File: doc/BRIEF.md
# Inter-Processor Doorbell Array with Per-Master Grant Masks

This block holds a row of doorbells, one per processor complex. A processor rings a doorbell by writing to its trigger location. Every register access carries the identifier of the master that issued it, so the doorbell records *who* rang as a separate bit. Each doorbell keeps a grant mask that lists the masters allowed to interrupt it. A ring from a master that is not granted is still recorded in a raw register, but it does not reach the pending register and cannot raise the interrupt. The doorbell's interrupt stays high while any of its pending bits is set. The owning processor reads the pending bits and writes the same value back to clear them.

Two independent register ports reach the same array, so rings and clears can arrive in the same clock cycle. Writes take effect at the next rising clock edge. Read data is a combinational view of the addressed register while a read is presented.

Top module: `doorbell_array`

## Requirements
- R1: After reset, every grant, raw and pending register reads zero and every interrupt output is low.
- R2: Doorbell d occupies addresses starting at d*STRIDE (default 0x100). Within a doorbell, offset 0x0 is the trigger, 0x4 the grant mask, 0x8 the raw record and 0xC the pending record. The trigger location reads zero. Any other offset, and any doorbell index at or above NUM_DB, reads zero and ignores writes.
- R3: A write to a trigger location with data bit 0 set, issued by master m, sets bit m of that doorbell's raw register at the next edge. A trigger write with bit 0 clear changes nothing.
- R4: The same ring sets pending bit m only if grant bit m holds 1 in the grant value present before that edge.
- R5: The interrupt output of doorbell d is high in the cycle after its pending register becomes non-zero, and low while that register is zero.
- R6: Writing to the raw or pending location clears every bit written as 1 and leaves bits written as 0 unchanged.
- R7: The grant mask is read/write, one bit per master (NUM_MASTERS bits). Bits above NUM_MASTERS read zero.
- R8: When a ring sets a bit and a clear of that same bit (raw or pending) arrive in the same cycle, the bit ends up set.
- R9: Rings from both ports in one cycle are merged, so both masters' bits are set. When both ports write the same grant mask in one cycle, the higher-numbered port's value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_PORTS | Access present on each port |
| req_write | input | NUM_PORTS | 1 = write, 0 = read, per port |
| req_addr | input | NUM_PORTS x ADDR_W | Byte address per port |
| req_wdata | input | NUM_PORTS x 32 | Write data per port |
| req_master | input | NUM_PORTS x log2(NUM_MASTERS) | Identifier of the issuing master per port |
| rd_data | output | NUM_PORTS x 32 | Read data per port, zero when no read is presented |
| irq | output | NUM_DB | Level interrupt per doorbell |

## Verification
Two things can collide in one cycle: a ring that sets a raw/pending bit, and a write-one-to-clear of that same bit. The bench provokes this by putting a trigger write from master 1 on one port and a clear of pending bit 1 of the same doorbell on the other port in the same cycle. The bit must survive, and the interrupt must stay high. Random two-port traffic over in-range and out-of-range doorbells repeats such collisions, along with same-cycle grant writes against rings. A behavioural model applies the set-over-clear and higher-port-wins rules, and every clock it is compared against the interrupt outputs and each read.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  localparam int unsigned REG_W = 32;

  // Register selector inside one doorbell window; value = offset[3:2].
  typedef enum logic [1:0] {
    REG_TRIG = 2'd0,
    REG_EN   = 2'd1,
    REG_RAW  = 2'd2,
    REG_PEND = 2'd3
  } reg_sel_e;

  // Doorbell index addressed by a byte address.
  function automatic logic [31:0] slot_index(input logic [31:0] a, input int unsigned stride);
    return a / stride;
  endfunction

  // Byte offset inside a doorbell window.
  function automatic logic [31:0] slot_offset(input logic [31:0] a, input int unsigned stride);
    return a % stride;
  endfunction

  // Only the four word-aligned offsets below 0x10 name a register.
  function automatic logic offset_known(input logic [31:0] off);
    return (off[31:4] == '0) && (off[1:0] == 2'b00);
  endfunction

  function automatic reg_sel_e offset_to_sel(input logic [31:0] off);
    return reg_sel_e'(off[3:2]);
  endfunction

  // One-hot bit for a master identifier.
  function automatic logic [31:0] master_bit(input logic [7:0] id);
    return 32'd1 << id;
  endfunction

  // Grant register update across ports: the last enabled port wins (R9).
  function automatic logic [31:0] grant_pick(input logic [31:0] cur,
                                             input logic [31:0] wa, input logic wa_en,
                                             input logic [31:0] wb, input logic wb_en);
    logic [31:0] r;
    r = cur;
    if (wa_en) r = wa;
    if (wb_en) r = wb;
    return r;
  endfunction

endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_DB = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned STRIDE = 256
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_DB-1:0] slot_oh,
  output reg_sel_e          sel,
  output logic              sel_ok
);

  logic [31:0] a32;
  logic [31:0] slot;
  logic [31:0] off;

  assign a32  = 32'(addr);
  assign slot = slot_index(a32, STRIDE);
  assign off  = slot_offset(a32, STRIDE);

  // R2: an index outside the array selects no doorbell
  always_comb begin
    for (int d = 0; d < int'(NUM_DB); d++) begin
      slot_oh[d] = (slot == 32'(d));
    end
  end

  assign sel_ok = offset_known(off) && (slot < 32'(NUM_DB));
  assign sel    = offset_to_sel(off);

endmodule

// File: rtl/doorbell_cell.sv
module doorbell_cell #(
  parameter int unsigned NUM_MASTERS = 32,
  parameter int unsigned NUM_PORTS   = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_PORTS-1:0]                  en_we,
  input  logic [NUM_PORTS-1:0][NUM_MASTERS-1:0] en_wd,
  input  logic [NUM_MASTERS-1:0]                ring,
  input  logic [NUM_MASTERS-1:0]                raw_clr,
  input  logic [NUM_MASTERS-1:0]                pend_clr,
  output logic [NUM_MASTERS-1:0]                en_q,
  output logic [NUM_MASTERS-1:0]                raw_q,
  output logic [NUM_MASTERS-1:0]                pend_q,
  output logic [NUM_MASTERS-1:0]                pend_set,
  output logic                                  irq
);

  logic [NUM_MASTERS-1:0] en_nxt;
  logic [NUM_MASTERS-1:0] raw_nxt;
  logic [NUM_MASTERS-1:0] pend_nxt;

  // R9: higher port index overrides lower
  always_comb begin
    en_nxt = en_q;
    for (int p = 0; p < int'(NUM_PORTS); p++) begin
      if (en_we[p]) en_nxt = en_wd[p];
    end
  end

  // R4: gate with the grant value held before the edge
  assign pend_set = ring & en_q;

  // R6, R8: clear first, then set so a ring wins
  assign raw_nxt  = (raw_q  & ~raw_clr)  | ring;
  assign pend_nxt = (pend_q & ~pend_clr) | pend_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      raw_q  <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_nxt;
      raw_q  <= raw_nxt;
      pend_q <= pend_nxt;
    end
  end

  // R5
  assign irq = |pend_q;

endmodule

// File: rtl/doorbell_rdmux.sv
module doorbell_rdmux
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_DB      = 8,
  parameter int unsigned NUM_MASTERS = 32
) (
  input  logic                               rd_act,
  input  logic [NUM_DB-1:0]                  slot_oh,
  input  reg_sel_e                           sel,
  input  logic [NUM_DB-1:0][NUM_MASTERS-1:0] en_vec,
  input  logic [NUM_DB-1:0][NUM_MASTERS-1:0] raw_vec,
  input  logic [NUM_DB-1:0][NUM_MASTERS-1:0] pend_vec,
  output logic [REG_W-1:0]                   data
);

  always_comb begin
    data = '0;
    if (rd_act) begin
      for (int d = 0; d < int'(NUM_DB); d++) begin
        if (slot_oh[d]) begin
          unique case (sel)
            REG_EN:   data[NUM_MASTERS-1:0] = en_vec[d];
            REG_RAW:  data[NUM_MASTERS-1:0] = raw_vec[d];
            REG_PEND: data[NUM_MASTERS-1:0] = pend_vec[d];
            default:  data = '0; // R2: trigger reads zero
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/doorbell_array.sv
module doorbell_array
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_DB      = 8,
  parameter int unsigned NUM_MASTERS = 32,
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned STRIDE      = 256,
  parameter int unsigned ADDR_W      = 12,
  localparam int unsigned MID_W      = $clog2(NUM_MASTERS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PORTS-1:0]             req_valid,
  input  logic [NUM_PORTS-1:0]             req_write,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] req_addr,
  input  logic [NUM_PORTS-1:0][REG_W-1:0]  req_wdata,
  input  logic [NUM_PORTS-1:0][MID_W-1:0]  req_master,
  output logic [NUM_PORTS-1:0][REG_W-1:0]  rd_data,
  output logic [NUM_DB-1:0]                irq
);

  // Named internal events (used by the bound checker)
  logic [NUM_PORTS-1:0][NUM_DB-1:0]      p_oh;
  reg_sel_e                              p_sel [NUM_PORTS];
  logic [NUM_PORTS-1:0]                  p_ok;
  logic [NUM_PORTS-1:0]                  p_wr;
  logic [NUM_PORTS-1:0]                  p_rd;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0]    en_vec;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0]    raw_vec;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0]    pend_vec;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0]    ring_vec;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0]    pend_set_vec;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0]    pend_clr_vec;

  // Per-port decode and read path
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    doorbell_decode #(
      .NUM_DB (NUM_DB),
      .ADDR_W (ADDR_W),
      .STRIDE (STRIDE)
    ) u_dec (
      .addr    (req_addr[p]),
      .slot_oh (p_oh[p]),
      .sel     (p_sel[p]),
      .sel_ok  (p_ok[p])
    );

    assign p_wr[p] = req_valid[p] &  req_write[p] & p_ok[p];
    assign p_rd[p] = req_valid[p] & ~req_write[p] & p_ok[p];

    doorbell_rdmux #(
      .NUM_DB      (NUM_DB),
      .NUM_MASTERS (NUM_MASTERS)
    ) u_rd (
      .rd_act   (p_rd[p]),
      .slot_oh  (p_oh[p]),
      .sel      (p_sel[p]),
      .en_vec   (en_vec),
      .raw_vec  (raw_vec),
      .pend_vec (pend_vec),
      .data     (rd_data[p])
    );
  end

  // Per-doorbell merge of all ports and state
  for (genvar d = 0; d < NUM_DB; d++) begin : g_db
    logic [NUM_MASTERS-1:0]                ring_m;
    logic [NUM_MASTERS-1:0]                raw_clr_m;
    logic [NUM_MASTERS-1:0]                pend_clr_m;
    logic [NUM_PORTS-1:0]                  en_we_m;
    logic [NUM_PORTS-1:0][NUM_MASTERS-1:0] en_wd_m;

    always_comb begin
      ring_m     = '0;
      raw_clr_m  = '0;
      pend_clr_m = '0;
      en_we_m    = '0;
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
        en_wd_m[p] = req_wdata[p][NUM_MASTERS-1:0];
        if (p_wr[p] && p_oh[p][d]) begin
          unique case (p_sel[p])
            // R3: bit 0 of the data requests the ring
            REG_TRIG: if (req_wdata[p][0])
                        ring_m = ring_m | master_bit(8'(req_master[p]))[NUM_MASTERS-1:0];
            REG_EN:   en_we_m[p] = 1'b1;
            REG_RAW:  raw_clr_m  = raw_clr_m  | req_wdata[p][NUM_MASTERS-1:0];
            REG_PEND: pend_clr_m = pend_clr_m | req_wdata[p][NUM_MASTERS-1:0];
            default:  ;
          endcase
        end
      end
    end

    doorbell_cell #(
      .NUM_MASTERS (NUM_MASTERS),
      .NUM_PORTS   (NUM_PORTS)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_we    (en_we_m),
      .en_wd    (en_wd_m),
      .ring     (ring_m),
      .raw_clr  (raw_clr_m),
      .pend_clr (pend_clr_m),
      .en_q     (en_vec[d]),
      .raw_q    (raw_vec[d]),
      .pend_q   (pend_vec[d]),
      .pend_set (pend_set_vec[d]),
      .irq      (irq[d])
    );

    assign ring_vec[d]     = ring_m;
    assign pend_clr_vec[d] = pend_clr_m;
  end

endmodule

// File: rtl/doorbell_array_chk.sv
module doorbell_array_chk #(
  parameter int unsigned NUM_DB      = 8,
  parameter int unsigned NUM_MASTERS = 32
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_DB-1:0]                  irq,
  input logic [NUM_DB-1:0][NUM_MASTERS-1:0] en_vec,
  input logic [NUM_DB-1:0][NUM_MASTERS-1:0] raw_vec,
  input logic [NUM_DB-1:0][NUM_MASTERS-1:0] pend_vec,
  input logic [NUM_DB-1:0][NUM_MASTERS-1:0] ring_vec,
  input logic [NUM_DB-1:0][NUM_MASTERS-1:0] pend_set_vec,
  input logic [NUM_DB-1:0][NUM_MASTERS-1:0] pend_clr_vec
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0));

  // R4
  pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & ~$past(pend_vec) & ~$past(en_vec)) == '0));

  // R3
  raw_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_vec & ~$past(raw_vec) & ~$past(ring_vec)) == '0));

  // R3
  raw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_vec != '0) |=> ((raw_vec & $past(ring_vec)) == $past(ring_vec)));

  // R8
  ring_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_set_vec & pend_clr_vec) != '0) |=>
      ((pend_vec & $past(pend_set_vec)) == $past(pend_set_vec)));

  for (genvar d = 0; d < NUM_DB; d++) begin : g_irq
    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[d]) |-> ($past(pend_set_vec[d]) != '0));
    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[d] && (pend_clr_vec[d] == '0)) |=> irq[d]);
  end

endmodule

bind doorbell_array doorbell_array_chk #(
  .NUM_DB      (NUM_DB),
  .NUM_MASTERS (NUM_MASTERS)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq          (irq),
  .en_vec       (en_vec),
  .raw_vec      (raw_vec),
  .pend_vec     (pend_vec),
  .ring_vec     (ring_vec),
  .pend_set_vec (pend_set_vec),
  .pend_clr_vec (pend_clr_vec)
);

// File: tb/test_doorbell_array.sv
module test_doorbell_array;

  localparam int NDB = 8;
  localparam int NP  = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NP-1:0]      v = '0;
  logic [NP-1:0]      w = '0;
  logic [NP-1:0][11:0] a = '0;
  logic [NP-1:0][31:0] wd = '0;
  logic [NP-1:0][4:0]  mid = '0;
  logic [NP-1:0][31:0] rd;
  logic [NDB-1:0]     irq;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_tag = "R1";

  // reference model state
  logic [31:0] m_en [NDB];
  logic [31:0] m_raw[NDB];
  logic [31:0] m_pnd[NDB];

  always #4 clk = ~clk;

  doorbell_array i_doorbell_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (v),
    .req_write  (w),
    .req_addr   (a),
    .req_wdata  (wd),
    .req_master (mid),
    .rd_data    (rd),
    .irq        (irq)
  );

  // address -> (doorbell, register code 1..4), 0 if none
  function automatic int reg_code(input logic [11:0] addr, output int db);
    db = int'(addr) / 256;
    if (db >= NDB) return 0;
    case (int'(addr) % 256)
      0:  return 1;
      4:  return 2;
      8:  return 3;
      12: return 4;
      default: return 0;
    endcase
  endfunction

  initial begin
    for (int d = 0; d < NDB; d++) begin m_en[d] = 0; m_raw[d] = 0; m_pnd[d] = 0; end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NDB; d++) begin m_en[d] = 0; m_raw[d] = 0; m_pnd[d] = 0; end
    end else begin
      for (int d = 0; d < NDB; d++) begin
        logic [31:0] sets, rclr, pclr, en_new;
        sets = 0; rclr = 0; pclr = 0; en_new = m_en[d];
        for (int p = 0; p < NP; p++) begin
          int db, c;
          c = reg_code(a[p], db);
          if (v[p] && w[p] && c != 0 && db == d) begin
            if (c == 1 && wd[p][0]) sets |= (32'd1 << mid[p]);
            if (c == 2) en_new = wd[p];
            if (c == 3) rclr |= wd[p];
            if (c == 4) pclr |= wd[p];
          end
        end
        m_raw[d] = (m_raw[d] & ~rclr) | sets;
        m_pnd[d] = (m_pnd[d] & ~pclr) | (sets & m_en[d]);
        m_en[d]  = en_new;
      end
    end
  end

  function automatic logic [31:0] model_read(input int p);
    int db, c;
    if (!(v[p] && !w[p])) return 0;
    c = reg_code(a[p], db);
    case (c)
      2: return m_en[db];
      3: return m_raw[db];
      4: return m_pnd[db];
      default: return 0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < NDB; d++) chk(32'(irq[d]), 32'(m_pnd[d] != 0), "R5 irq");
      for (int p = 0; p < NP; p++)
        if (v[p] && !w[p]) chk(rd[p], model_read(p), cur_tag);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    v = '0; w = '0; a = '0; wd = '0; mid = '0;
  endtask

  task automatic put(input int p, input bit wr, input int addr, input logic [31:0] data, input int m);
    v[p] = 1'b1; w[p] = wr; a[p] = 12'(addr); wd[p] = data; mid[p] = 5'(m);
  endtask

  task automatic wr1(input int p, input int addr, input logic [31:0] data, input int m);
    idle(); put(p, 1, addr, data, m); tick(); idle();
  endtask

  task automatic rd1(input int p, input int addr);
    idle(); put(p, 0, addr, 0, 0); tick(); idle();
  endtask

  task automatic rd_all(input int d);
    rd1(0, d*256 + 0); rd1(0, d*256 + 4); rd1(1, d*256 + 8); rd1(1, d*256 + 12);
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1: everything zero after reset
    cur_tag = "R1 reset";
    for (int d = 0; d < NDB; d++) rd_all(d);

    // R7: grant masks read back
    cur_tag = "R7 grant";
    wr1(0, 1*256 + 4, 32'h0000_000A, 1);
    wr1(1, 2*256 + 4, 32'hFFFF_FFFF, 3);
    rd1(0, 1*256 + 4); rd1(1, 2*256 + 4);

    // R3/R4: granted master 3 rings doorbell 1, ungranted master 5 too
    cur_tag = "R4 gated ring";
    wr1(0, 1*256 + 0, 32'h1, 3);
    wr1(1, 1*256 + 0, 32'h1, 5);
    rd1(0, 1*256 + 8); rd1(0, 1*256 + 12);

    // R3: trigger without bit 0 does nothing
    cur_tag = "R3 no ring";
    wr1(0, 3*256 + 0, 32'hFFFF_FFFE, 1);
    rd1(0, 3*256 + 8); rd1(0, 3*256 + 12);

    // R6: write-one-to-clear on pending and raw
    cur_tag = "R6 clear";
    wr1(1, 1*256 + 12, 32'h0000_0008, 1);
    wr1(0, 1*256 + 8,  32'h0000_0020, 1);
    rd1(0, 1*256 + 8); rd1(1, 1*256 + 12);

    // R8: ring by master 1 and clear of pending bit 1 in one cycle
    cur_tag = "R8 ring wins";
    wr1(0, 1*256 + 0, 32'h1, 1);
    idle();
    put(0, 1, 1*256 + 0,  32'h1, 1);
    put(1, 1, 1*256 + 12, 32'h2, 3);
    tick(); idle();
    rd1(0, 1*256 + 12);
    put(0, 1, 1*256 + 0, 32'h1, 1);
    put(1, 1, 1*256 + 8, 32'h2, 3);
    tick(); idle();
    rd1(1, 1*256 + 8);

    // R9: both ports ring doorbell 2, both write grant of doorbell 4
    cur_tag = "R9 merge";
    put(0, 1, 2*256 + 0, 32'h1, 1);
    put(1, 1, 2*256 + 0, 32'h1, 3);
    tick(); idle();
    rd1(0, 2*256 + 12); rd1(1, 2*256 + 8);
    put(0, 1, 4*256 + 4, 32'h1111_0000, 1);
    put(1, 1, 4*256 + 4, 32'h0000_2222, 3);
    tick(); idle();
    rd1(0, 4*256 + 4);

    // R2: holes and out-of-range doorbells
    cur_tag = "R2 map";
    wr1(0, 8*256 + 4, 32'hFFFF_FFFF, 1);
    wr1(0, 5*256 + 16, 32'hFFFF_FFFF, 1);
    wr1(0, 5*256 + 2, 32'hFFFF_FFFF, 1);
    rd1(0, 8*256 + 4); rd1(0, 5*256 + 16); rd1(1, 5*256 + 4); rd1(1, 2*256 + 0);

    // R5 and all rules: random two-port traffic
    cur_tag = "R5 random";
    for (int i = 0; i < 3000; i++) begin
      idle();
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(0, 3) != 0) begin
          int db, offs, m;
          logic [31:0] data;
          db = $urandom_range(0, NDB);
          case ($urandom_range(0, 5))
            0, 1: offs = 0;
            2:    offs = 4;
            3:    offs = 8;
            4:    offs = 12;
            default: offs = 16;
          endcase
          m = ($urandom_range(0, 1) != 0) ? (($urandom_range(0, 1) != 0) ? 1 : 3)
                                          : int'($urandom_range(0, 31));
          data = $urandom;
          if (offs == 0) data[0] = ($urandom_range(0, 3) != 0);
          put(p, $urandom_range(0, 1) != 0, db*256 + offs, data, m);
        end
      end
      tick();
    end
    idle(); tick();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule